// File: doc/BRIEF.md
# Load-Store Disambiguation Buffer

This block keeps every in-flight memory operation of a speculative core in program order. That lets loads run ahead of earlier stores whose addresses are still unknown. An operation takes an entry when it issues. At that point it carries only its kind and, for a store, the reservation-station tag of the instruction that will produce the store's data. Addresses and store data arrive later, in any order, and are written into the entry by its index.

Each address arrival starts an associative search. When a load's address arrives, the buffer looks at the older stores whose addresses are known. If the youngest one with the same address already holds its data, that value is forwarded. If that store's data is not there yet, the producer tag is returned instead. If no older store matches, the load may go to memory at once.

When a store's address arrives, the buffer looks at the younger loads that have already resolved. If one has the same address, it was speculated wrongly. The buffer then signals a flush naming the oldest such load, and drops that load together with everything younger than it. Entries leave from the head, in order, on retire.

Top module: `lsdb_top`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `res_valid` and `flush_valid` are 0.
- R2: Allocation is a valid/ready handshake. An operation is accepted on a cycle with `alloc_valid` and `alloc_ready` both high, and it takes entry index `alloc_idx`. Indices advance by one per accepted operation and wrap modulo 8. After 8 entries are held, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R3: A `retire_valid` pulse frees the oldest entry. `alloc_ready` is 1 again in the next cycle. A retire while the buffer is empty is ignored.
- R4: A load address resolves on a cycle with `addr_valid` high and `addr_idx` naming a load entry. One cycle later `res_valid` is 1 and `res_idx` names the load. If no older store with a known address has the same address, `res_kind` is 0 (go to memory). Stores with unknown addresses and younger stores never match.
- R5: If the matching older store holds its data, `res_kind` is 1 and `res_data` carries that data.
- R6: If the matching older store has no data yet, `res_kind` is 2 and `res_tag` carries the store's producer tag.
- R7: When several older stores match, the youngest of them is chosen. Age is counted from the head, and this holds across index wrap.
- R8: Store data that arrives in the same cycle as the load's address, through `data_valid`/`data_idx`, is forwarded as if it were already stored.
- R9: A store address resolves on a cycle with `addr_valid` high and `addr_idx` naming a store entry. If any younger load has resolved to the same address, `flush_valid` is 1 one cycle later, and `flush_idx` names the oldest such load. Younger loads that have not resolved, and loads to another address, cause no flush.
- R10: A flush removes the offending load and all younger entries, so the next allocation reuses the load's index. An allocation accepted in the flushing cycle is discarded as well.
- R11: A load older than the resolving store never causes a flush, even when its address is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | An operation is offered for allocation |
| alloc_ready | output | 1 | The buffer has a free entry |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_tag | input | 6 | Producer tag of the store's data |
| alloc_idx | output | 3 | Entry index the offered operation would take |
| addr_valid | input | 1 | An address resolves this cycle |
| addr_idx | input | 3 | Entry whose address resolves |
| addr_value | input | 32 | Resolved address |
| data_valid | input | 1 | Store data is ready this cycle |
| data_idx | input | 3 | Store entry receiving data |
| data_value | input | 32 | Store data |
| retire_valid | input | 1 | Free the oldest entry |
| res_valid | output | 1 | Load search result is valid |
| res_idx | output | 3 | Load the result belongs to |
| res_kind | output | 2 | 0 memory, 1 forwarded, 2 wait on tag |
| res_data | output | 32 | Forwarded data when the kind is 1 |
| res_tag | output | 6 | Producer tag when the kind is 2 |
| flush_valid | output | 1 | A younger load was mis-speculated |
| flush_idx | output | 3 | Oldest mis-speculated load |

## Verification
Two pairs of functions can meet in one cycle. Store data can arrive in the same cycle that a younger load resolves to that store's address. The bench drives both on one edge, while a second matching store without data is also present. The result must be a forward of the new value, not a wait on the tag. A store resolution that triggers a flush can also coincide with an accepted allocation. The bench drives both together, and then checks through `alloc_idx` and a later fill to full that the new entry was dropped.

// File: rtl/lsdb_pkg.sv
package lsdb_pkg;
  typedef enum logic [1:0] {
    RES_MEM  = 2'd0,
    RES_FWD  = 2'd1,
    RES_WAIT = 2'd2
  } res_kind_e;
endpackage

// File: rtl/lsdb_ring.sv
module lsdb_ring #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic          alloc_fire,
  input  logic          retire_req,
  output logic          retire_fire,
  input  logic          flush_req,
  input  logic [IW-1:0] flush_to,
  input  logic [IW:0]   flush_cnt,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [IW:0]   cnt
);
  localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

  logic [IW:0] cnt_nxt;

  assign alloc_ready = (cnt != FULL_CNT);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_req && (cnt != '0);

  always_comb begin
    cnt_nxt = cnt;
    if (flush_req)       cnt_nxt = flush_cnt;
    else if (alloc_fire) cnt_nxt = cnt_nxt + 1'b1;
    if (retire_fire)     cnt_nxt = cnt_nxt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (retire_fire) head <= head + 1'b1;
      if (flush_req)       tail <= flush_to;
      else if (alloc_fire) tail <= tail + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT); // R2
  AST_EMPTY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !alloc_valid) |=> (cnt == '0)); // R3
endmodule

// File: rtl/lsdb_age_pick.sv
module lsdb_age_pick #(
  parameter int DEPTH          = 8,
  parameter int IW             = $clog2(DEPTH),
  parameter bit YOUNGEST_OLDER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] cand,
  input  logic [IW-1:0]    head,
  input  logic [IW-1:0]    ref_idx,
  output logic             hit,
  output logic [IW-1:0]    sel
);
  logic [IW-1:0] ref_age;
  assign ref_age = ref_idx - head;

  generate
    if (YOUNGEST_OLDER) begin : g_youngest_older
      always_comb begin
        hit = 1'b0;
        sel = head;
        for (int k = 0; k < DEPTH; k++) begin
          if (IW'(k) < ref_age && cand[head + IW'(k)]) begin
            hit = 1'b1;
            sel = head + IW'(k);
          end
        end
      end
    end else begin : g_oldest_younger
      always_comb begin
        hit = 1'b0;
        sel = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
          if (IW'(k) > ref_age && cand[head + IW'(k)]) begin
            hit = 1'b1;
            sel = head + IW'(k);
          end
        end
      end
    end
  endgenerate

  AST_PICK_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cand[sel]); // R7
endmodule

// File: rtl/lsdb_top.sv
module lsdb_top #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 6,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic          alloc_is_store,
  input  logic [TW-1:0] alloc_tag,
  output logic [IW-1:0] alloc_idx,
  input  logic          addr_valid,
  input  logic [IW-1:0] addr_idx,
  input  logic [AW-1:0] addr_value,
  input  logic          data_valid,
  input  logic [IW-1:0] data_idx,
  input  logic [DW-1:0] data_value,
  input  logic          retire_valid,
  output logic          res_valid,
  output logic [IW-1:0] res_idx,
  output logic [1:0]    res_kind,
  output logic [DW-1:0] res_data,
  output logic [TW-1:0] res_tag,
  output logic          flush_valid,
  output logic [IW-1:0] flush_idx
);
  import lsdb_pkg::*;

  logic          e_vld [DEPTH];
  logic          e_st  [DEPTH];
  logic          e_aok [DEPTH];
  logic          e_dok [DEPTH];
  logic          e_exe [DEPTH];
  logic [AW-1:0] e_adr [DEPTH];
  logic [DW-1:0] e_dat [DEPTH];
  logic [TW-1:0] e_tag [DEPTH];

  logic [IW-1:0] head, tail;
  logic [IW:0]   cnt;
  logic          alloc_fire, retire_fire;

  logic [DEPTH-1:0] st_cand, ld_cand;
  logic             st_hit, ld_hit;
  logic [IW-1:0]    st_sel, ld_sel, cut_age;
  logic             rs_ld, rs_st, do_flush;
  logic             bypass, sel_dok;
  logic [DW-1:0]    sel_dat;
  res_kind_e        kind_nxt;

  assign rs_ld    = addr_valid && e_vld[addr_idx] && !e_st[addr_idx];
  assign rs_st    = addr_valid && e_vld[addr_idx] &&  e_st[addr_idx];
  assign do_flush = rs_st && ld_hit;
  assign cut_age  = ld_sel - head;
  assign alloc_idx = tail;

  lsdb_ring #(.DEPTH(DEPTH), .IW(IW)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_fire(alloc_fire),
    .retire_req(retire_valid), .retire_fire(retire_fire),
    .flush_req(do_flush), .flush_to(ld_sel), .flush_cnt({1'b0, cut_age}),
    .head(head), .tail(tail), .cnt(cnt)
  );

  lsdb_age_pick #(.DEPTH(DEPTH), .IW(IW), .YOUNGEST_OLDER(1'b1)) u_st_pick (
    .clk(clk), .rst_n(rst_n), .cand(st_cand), .head(head), .ref_idx(addr_idx),
    .hit(st_hit), .sel(st_sel)
  );

  lsdb_age_pick #(.DEPTH(DEPTH), .IW(IW), .YOUNGEST_OLDER(1'b0)) u_ld_pick (
    .clk(clk), .rst_n(rst_n), .cand(ld_cand), .head(head), .ref_idx(addr_idx),
    .hit(ld_hit), .sel(ld_sel)
  );

  // Same-cycle store data is visible to the load search.
  assign bypass  = data_valid && (data_idx == st_sel);
  assign sel_dok = e_dok[st_sel] || bypass;
  assign sel_dat = bypass ? data_value : e_dat[st_sel];

  always_comb begin
    if (!st_hit)      kind_nxt = RES_MEM;
    else if (sel_dok) kind_nxt = RES_FWD;
    else              kind_nxt = RES_WAIT;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IW-1:0] age_i;
    assign age_i = IW'(i) - head;
    assign st_cand[i] = e_vld[i] &&  e_st[i] && e_aok[i] && (e_adr[i] == addr_value);
    assign ld_cand[i] = e_vld[i] && !e_st[i] && e_exe[i] && (e_adr[i] == addr_value);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_vld[i] <= 1'b0;
        e_st[i]  <= 1'b0;
        e_aok[i] <= 1'b0;
        e_dok[i] <= 1'b0;
        e_exe[i] <= 1'b0;
        e_adr[i] <= '0;
        e_dat[i] <= '0;
        e_tag[i] <= '0;
      end else begin
        if (retire_fire && head == IW'(i)) e_vld[i] <= 1'b0;
        if (alloc_fire && tail == IW'(i)) begin
          e_vld[i] <= 1'b1;
          e_st[i]  <= alloc_is_store;
          e_aok[i] <= 1'b0;
          e_dok[i] <= 1'b0;
          e_exe[i] <= 1'b0;
          e_tag[i] <= alloc_tag;
        end
        if (addr_valid && e_vld[i] && addr_idx == IW'(i)) begin
          e_aok[i] <= 1'b1;
          e_adr[i] <= addr_value;
          e_exe[i] <= !e_st[i];
        end
        if (data_valid && e_vld[i] && data_idx == IW'(i)) begin
          e_dok[i] <= 1'b1;
          e_dat[i] <= data_value;
        end
        if (do_flush && age_i >= cut_age) e_vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_idx     <= '0;
      res_kind    <= 2'd0;
      res_data    <= '0;
      res_tag     <= '0;
      flush_valid <= 1'b0;
      flush_idx   <= '0;
    end else begin
      res_valid   <= rs_ld;
      res_idx     <= addr_idx;
      res_kind    <= kind_nxt;
      res_data    <= (st_hit && sel_dok) ? sel_dat : '0;
      res_tag     <= st_hit ? e_tag[st_sel] : '0;
      flush_valid <= do_flush;
      flush_idx   <= ld_sel;
    end
  end

  AST_RES_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(addr_valid)); // R4
  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && flush_valid)); // R9
  AST_FLUSH_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (alloc_idx == flush_idx)); // R10
endmodule

// File: tb/lsdb_top_tb.sv
`timescale 1ns/1ps
module lsdb_top_tb;
  localparam int DEPTH = 8;
  localparam int IW = 3;
  localparam int TW = 6;
  localparam logic [1:0] K_MEM = 2'd0, K_FWD = 2'd1, K_WAIT = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_is_store = 0, addr_valid = 0, data_valid = 0, retire_valid = 0;
  logic [TW-1:0] alloc_tag = '0;
  logic [IW-1:0] addr_idx = '0, data_idx = '0;
  logic [31:0] addr_value = '0, data_value = '0;
  logic alloc_ready, res_valid, flush_valid;
  logic [IW-1:0] alloc_idx, res_idx, flush_idx;
  logic [1:0] res_kind;
  logic [31:0] res_data;
  logic [TW-1:0] res_tag;

  lsdb_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_is_store(alloc_is_store),
    .alloc_tag(alloc_tag), .alloc_idx(alloc_idx),
    .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
    .data_valid(data_valid), .data_idx(data_idx), .data_value(data_value),
    .retire_valid(retire_valid),
    .res_valid(res_valid), .res_idx(res_idx), .res_kind(res_kind), .res_data(res_data),
    .res_tag(res_tag), .flush_valid(flush_valid), .flush_idx(flush_idx)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0]  ek_q[$];
  int          ei_q[$];
  logic [31:0] ev_q[$];
  string       er_q[$];
  int          fi_q[$];
  string       fr_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_res(input logic [1:0] k, input int idx, input logic [31:0] v, input string req);
    ek_q.push_back(k); ei_q.push_back(idx); ev_q.push_back(v); er_q.push_back(req);
  endtask

  task automatic expect_flush(input int idx, input string req);
    fi_q.push_back(idx); fr_q.push_back(req);
  endtask

  // Monitor: compares results and flushes against the scoreboard queues.
  always @(negedge clk) begin
    logic [1:0] k; int i; logic [31:0] v; string r;
    if (rst_n && res_valid) begin
      if (ek_q.size() == 0) check(1'b0, "R4", "unexpected result", 64'(res_idx), 64'hff);
      else begin
        k = ek_q.pop_front(); i = ei_q.pop_front(); v = ev_q.pop_front(); r = er_q.pop_front();
        check(res_kind == k && res_idx == IW'(i), r, "result kind/idx",
              64'({res_kind, res_idx}), 64'({k, IW'(i)}));
        if (k == K_FWD) check(res_data == v, r, "forwarded data", 64'(res_data), 64'(v));
        if (k == K_WAIT) check(res_tag == v[TW-1:0], r, "producer tag", 64'(res_tag), 64'(v[TW-1:0]));
      end
    end
    if (rst_n && flush_valid) begin
      if (fi_q.size() == 0) check(1'b0, "R11", "unexpected flush", 64'(flush_idx), 64'hff);
      else begin
        i = fi_q.pop_front(); r = fr_q.pop_front();
        check(flush_idx == IW'(i), r, "flush index", 64'(flush_idx), 64'(i));
      end
    end
  end

  task automatic tick;
    @(posedge clk); #1;
    alloc_valid = 0; addr_valid = 0; data_valid = 0; retire_valid = 0;
  endtask

  task automatic do_alloc(input bit st, input logic [TW-1:0] tag, input int exp_idx, input string req);
    @(negedge clk);
    check(alloc_ready == 1'b1, req, "alloc_ready", 64'(alloc_ready), 64'd1);
    check(alloc_idx == IW'(exp_idx), req, "alloc_idx", 64'(alloc_idx), 64'(exp_idx));
    alloc_valid = 1; alloc_is_store = st; alloc_tag = tag;
    tick();
  endtask

  task automatic do_addr(input int idx, input logic [31:0] a);
    @(negedge clk);
    addr_valid = 1; addr_idx = IW'(idx); addr_value = a;
    tick();
  endtask

  task automatic do_data(input int idx, input logic [31:0] d);
    @(negedge clk);
    data_valid = 1; data_idx = IW'(idx); data_value = d;
    tick();
  endtask

  task automatic do_retire;
    @(negedge clk);
    retire_valid = 1;
    tick();
  endtask

  task automatic chk_noflush(input string req);
    @(negedge clk);
    check(flush_valid == 1'b0, req, "no flush", 64'(flush_valid), 64'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(alloc_ready == 1'b1, "R1", "reset alloc_ready", 64'(alloc_ready), 64'd1);
    check(alloc_idx == '0, "R1", "reset alloc_idx", 64'(alloc_idx), 64'd0);
    check(res_valid == 1'b0, "R1", "reset res_valid", 64'(res_valid), 64'd0);
    check(flush_valid == 1'b0, "R1", "reset flush_valid", 64'(flush_valid), 64'd0);

    // Program order: S0 S1 L2 S3 L4
    do_alloc(1, 6'd5, 0, "R2");
    do_alloc(1, 6'd6, 1, "R2");
    do_alloc(0, 6'd0, 2, "R2");
    do_alloc(1, 6'd7, 3, "R2");
    do_alloc(0, 6'd0, 4, "R2");
    expect_res(K_MEM, 2, 0, "R4");          // no store address known yet
    do_addr(2, 32'h80);
    do_addr(0, 32'h40);
    chk_noflush("R9");                      // L2 has another address
    do_data(0, 32'h1111);
    do_addr(3, 32'h40);
    chk_noflush("R9");                      // L4 not yet resolved
    expect_res(K_WAIT, 4, 32'd7, "R6");     // youngest older is S3, no data (R7)
    do_addr(4, 32'h40);
    do_alloc(0, 6'd0, 5, "R2");
    do_data(3, 32'h3333);
    expect_res(K_FWD, 5, 32'h3333, "R5");   // S3 chosen over S0 (R7)
    do_addr(5, 32'h40);
    expect_flush(4, "R9");                  // S1 resolves: L4 and L5 aliased, oldest L4
    do_addr(1, 32'h40);
    // R10: L4 and L5 removed; index 4 reused
    do_alloc(1, 6'd9, 4, "R10");
    do_addr(4, 32'h40);
    chk_noflush("R9");
    do_alloc(0, 6'd0, 5, "R2");
    expect_res(K_FWD, 5, 32'h4444, "R8");   // data for S4 arrives in the same cycle
    @(negedge clk);
    addr_valid = 1; addr_idx = 3'd5; addr_value = 32'h40;
    data_valid = 1; data_idx = 3'd4; data_value = 32'h4444;
    tick();
    do_alloc(1, 6'd10, 6, "R2");
    do_alloc(0, 6'd0, 7, "R2");
    do_addr(6, 32'h80);
    chk_noflush("R11");                     // L2 is older, L7 unresolved
    check(alloc_ready == 1'b0, "R2", "full stall", 64'(alloc_ready), 64'd0);
    @(negedge clk);
    alloc_valid = 1; alloc_is_store = 0;
    tick();
    @(negedge clk);
    check(alloc_ready == 1'b0, "R2", "still full", 64'(alloc_ready), 64'd0);
    check(alloc_idx == 3'd0, "R2", "ignored alloc idx", 64'(alloc_idx), 64'd0);
    do_retire();
    @(negedge clk);
    check(alloc_ready == 1'b1, "R3", "ready after retire", 64'(alloc_ready), 64'd1);
    do_alloc(0, 6'd0, 0, "R3");
    expect_res(K_WAIT, 0, 32'd10, "R7");    // wrapped youngest load, youngest older store S6
    do_addr(0, 32'h80);
    for (int n = 0; n < 8; n++) do_retire();
    do_retire();                            // empty retire is ignored (R3)
    do_alloc(1, 6'd11, 1, "R3");
    do_alloc(0, 6'd0, 2, "R3");
    expect_res(K_MEM, 2, 0, "R4");          // S1 address unknown: no match
    do_addr(2, 32'h200);
    expect_flush(2, "R10");
    @(negedge clk);                         // flushing store together with an allocation
    addr_valid = 1; addr_idx = 3'd1; addr_value = 32'h200;
    alloc_valid = 1; alloc_is_store = 0;
    tick();
    for (int n = 0; n < 7; n++) do_alloc(0, 6'd0, (n + 2) % DEPTH, "R10");
    @(negedge clk);
    check(alloc_ready == 1'b0, "R3", "exact occupancy full", 64'(alloc_ready), 64'd0);

    repeat (2) @(negedge clk);
    check(ek_q.size() == 0, "R4", "results outstanding", 64'(ek_q.size()), 64'd0);
    check(fi_q.size() == 0, "R9", "flushes outstanding", 64'(fi_q.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule